// File: doc/BRIEF.md
# Lease-Guarded Programmed-I/O Read Host Sequencer

This block is the host side of a programmed-I/O data-in command toward a register-based storage device controller. A read request arrives with a sector count and an interrupt-mode flag. The sequencer first checks the range of the count. It then waits for the device to drop its busy flag and writes the command. After that it waits for data. In interrupt mode it watches the interrupt line; in polled mode it watches the data-request status bit. It moves one buffer per data indication until the remaining count reaches zero, then signals completion.

A lease counter bounds every wait on the device. The host loads it to a fixed reload value each time it starts waiting for data, and it counts down by one each clock, stopping at zero. If the lease runs out while the host waits, the host pulses a device reset and returns to idle. The busy check before the command also has a retry limit. Together the two mechanisms bring both sides back to a known idle pair from any state, so the pair can neither deadlock nor livelock.

Top module: `lease_guard_pio_host`

## Requirements
- R1: After reset, host_state reads 0 (idle), lease_val reads 0, and cmd_wr, buf_rd, done, fail and dev_rst are all low.
- R2: A request whose req_count exceeds MAX_COUNT (127 by default) gives a one-cycle fail pulse, issues no cmd_wr, and leaves host_state at 0.
- R3: With host_state 1 (check ready), no command is written while dev_busy is high. The first clock with dev_busy low gives a one-cycle cmd_wr, with cmd_count equal to the accepted count.
- R4: After the command is written, host_state becomes 2 (wait for interrupt) if req_irq_mode was 1 at the request, and 3 (poll status) otherwise.
- R5: From state 2 only dev_intrq leads to state 4 (transfer); dev_drq is ignored there. From state 3 only dev_drq leads to state 4; dev_intrq is ignored there.
- R6: Each visit to state 4 gives exactly one buf_rd cycle. After the buffer that takes the count to zero, done pulses for one cycle and host_state returns to 0. Otherwise the host goes back to state 2 or 3 according to its mode.
- R7: An accepted count of 0 writes the command, then pulses done and returns to idle with no buf_rd.
- R8: lease_val is loaded with LEASE_RELOAD on each entry into state 2 or 3. It then falls by exactly one per clock and stays at 0 once there.
- R9: In state 2 or 3, with the lease at 0 and no data indication, the host gives a one-cycle dev_rst and goes to state 0 on the next clock.
- R10: If dev_busy is high for RETRY_LIMIT consecutive clocks in state 1, the last of those clocks gives a one-cycle dev_rst and a return to state 0, with no cmd_wr.
- R11: req_valid is ignored while the host is not idle; the running command keeps its count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Read request strobe, taken only in idle |
| req_count | input | CNT_W | Requested sector count |
| req_irq_mode | input | 1 | 1 selects interrupt wait, 0 selects status polling |
| dev_busy | input | 1 | Device busy status |
| dev_drq | input | 1 | Device data-request status bit |
| dev_intrq | input | 1 | Device interrupt line |
| cmd_wr | output | 1 | One-cycle command parameter write |
| cmd_count | output | CNT_W | Count carried with the command write |
| buf_rd | output | 1 | One buffer read, high during a transfer cycle |
| done | output | 1 | One-cycle command completion |
| fail | output | 1 | One-cycle rejection of a bad count |
| dev_rst | output | 1 | One-cycle device reset after an expired lease or busy timeout |
| lease_val | output | LEASE_W | Current lease counter value |
| host_state | output | 3 | Host state code 0..4 |

## Verification
The main read path is driven from a vector table that varies the count (0, 1, several, the limit 127 and values above it), the wait mode, the number of busy cycles before readiness, and the response delay. The 0 and above-limit entries separate the command-only and reject paths from a normal transfer. Comparing the buf_rd and done totals against the count exposes an off-by-one in the buffer loop. The mode and busy entries show whether the wait state follows the latched mode and whether readiness is honoured. Directed cases send the wrong data indication for the mode, let the lease run out with its value traced cycle by cycle, hold busy past the retry limit, and issue a request mid-command. Each of these has only one correct cycle at which to recover.

// File: rtl/pio_lease_pkg.sv
package pio_lease_pkg;
  typedef enum logic [2:0] {
    HS_IDLE      = 3'd0,
    HS_CHKRDY    = 3'd1,
    HS_WAIT_INT  = 3'd2,
    HS_WAIT_POLL = 3'd3,
    HS_XFER      = 3'd4
  } host_st_e;
endpackage

// File: rtl/lease_timer.sv
module lease_timer #(
  parameter int unsigned LEASE_W      = 16,
  parameter int unsigned LEASE_RELOAD = 1000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  output logic [LEASE_W-1:0] val,
  output logic               zero
);
  localparam logic [LEASE_W-1:0] RELOAD_V = LEASE_W'(LEASE_RELOAD);

  logic [LEASE_W-1:0] val_q, val_d;
  logic               val_en;

  always_comb begin
    val_en = 1'b0;
    val_d  = val_q;
    if (load) begin
      val_en = 1'b1;
      val_d  = RELOAD_V;
    end else if (val_q != '0) begin
      val_en = 1'b1;
      val_d  = val_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      val_q <= '0;
    else if (val_en) val_q <= val_d;
  end

  assign val  = val_q;
  assign zero = (val_q == '0);
endmodule

// File: rtl/busy_retry_counter.sv
module busy_retry_counter #(
  parameter int unsigned RETRY_LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic inc,
  output logic at_limit
);
  localparam int unsigned RW = (RETRY_LIMIT < 2) ? 1 : $clog2(RETRY_LIMIT);
  localparam logic [RW-1:0] LAST_V = RW'(RETRY_LIMIT - 1);

  logic [RW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (clear) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
    end else if (inc && cnt_q != LAST_V) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign at_limit = (cnt_q == LAST_V);
endmodule

// File: rtl/buffer_tracker.sv
module buffer_tracker #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic [CNT_W-1:0] remaining,
  output logic             last,
  output logic             empty
);
  logic [CNT_W-1:0] rem_q, rem_d;
  logic             rem_en;

  always_comb begin
    rem_en = 1'b0;
    rem_d  = rem_q;
    if (load) begin
      rem_en = 1'b1;
      rem_d  = load_val;
    end else if (dec && rem_q != '0) begin
      rem_en = 1'b1;
      rem_d  = rem_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rem_q <= '0;
    else if (rem_en) rem_q <= rem_d;
  end

  assign remaining = rem_q;
  assign last      = (rem_q == CNT_W'(1));
  assign empty     = (rem_q == '0);
endmodule

// File: rtl/pio_host_fsm.sv
module pio_host_fsm
  import pio_lease_pkg::*;
#(
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned MAX_COUNT = 127
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [CNT_W-1:0] req_count,
  input  logic             req_irq_mode,
  input  logic             dev_busy,
  input  logic             dev_drq,
  input  logic             dev_intrq,
  input  logic             lease_zero,
  input  logic             retry_at_limit,
  input  logic             buf_last,
  input  logic             buf_empty,
  input  logic [CNT_W-1:0] buf_remaining,
  output logic             lease_load,
  output logic             retry_clear,
  output logic             retry_inc,
  output logic             buf_load,
  output logic             buf_dec,
  output logic             cmd_wr,
  output logic [CNT_W-1:0] cmd_count,
  output logic             buf_rd,
  output logic             done,
  output logic             fail,
  output logic             dev_rst,
  output logic [2:0]       state
);
  localparam logic [CNT_W-1:0] MAX_V = CNT_W'(MAX_COUNT);

  host_st_e         st_q, st_d;
  logic             mode_q, mode_d;
  logic             cmd_q, cmd_d;
  logic             done_q, done_d;
  logic             fail_q, fail_d;
  logic             drst_q, drst_d;
  logic [CNT_W-1:0] ccnt_q;
  host_st_e         wait_st;

  assign wait_st = mode_q ? HS_WAIT_INT : HS_WAIT_POLL;

  always_comb begin
    st_d        = st_q;
    mode_d      = mode_q;
    cmd_d       = 1'b0;
    done_d      = 1'b0;
    fail_d      = 1'b0;
    drst_d      = 1'b0;
    lease_load  = 1'b0;
    retry_clear = 1'b0;
    retry_inc   = 1'b0;
    buf_load    = 1'b0;
    buf_dec     = 1'b0;
    case (st_q)
      HS_IDLE: begin
        retry_clear = 1'b1;
        if (req_valid) begin
          if (req_count > MAX_V) begin
            fail_d = 1'b1;
          end else begin
            buf_load = 1'b1;
            mode_d   = req_irq_mode;
            st_d     = HS_CHKRDY;
          end
        end
      end
      HS_CHKRDY: begin
        if (!dev_busy) begin
          cmd_d = 1'b1;
          if (buf_empty) begin
            done_d = 1'b1;
            st_d   = HS_IDLE;
          end else begin
            lease_load = 1'b1;
            st_d       = wait_st;
          end
        end else if (retry_at_limit) begin
          drst_d = 1'b1;
          st_d   = HS_IDLE;
        end else begin
          retry_inc = 1'b1;
        end
      end
      HS_WAIT_INT: begin
        if (dev_intrq) begin
          st_d = HS_XFER;
        end else if (lease_zero) begin
          drst_d = 1'b1;
          st_d   = HS_IDLE;
        end
      end
      HS_WAIT_POLL: begin
        if (dev_drq) begin
          st_d = HS_XFER;
        end else if (lease_zero) begin
          drst_d = 1'b1;
          st_d   = HS_IDLE;
        end
      end
      HS_XFER: begin
        buf_dec = 1'b1;
        if (buf_last || buf_empty) begin
          done_d = 1'b1;
          st_d   = HS_IDLE;
        end else begin
          lease_load = 1'b1;
          st_d       = wait_st;
        end
      end
      default: st_d = HS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= HS_IDLE;
      mode_q <= 1'b0;
      cmd_q  <= 1'b0;
      done_q <= 1'b0;
      fail_q <= 1'b0;
      drst_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      mode_q <= mode_d;
      cmd_q  <= cmd_d;
      done_q <= done_d;
      fail_q <= fail_d;
      drst_q <= drst_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ccnt_q <= '0;
    else if (cmd_d) ccnt_q <= buf_remaining;
  end

  assign cmd_wr    = cmd_q;
  assign cmd_count = ccnt_q;
  assign buf_rd    = (st_q == HS_XFER);
  assign done      = done_q;
  assign fail      = fail_q;
  assign dev_rst   = drst_q;
  assign state     = st_q;
endmodule

// File: rtl/lease_guard_pio_host.sv
module lease_guard_pio_host #(
  parameter int unsigned CNT_W        = 8,
  parameter int unsigned MAX_COUNT    = 127,
  parameter int unsigned LEASE_W      = 16,
  parameter int unsigned LEASE_RELOAD = 1000,
  parameter int unsigned RETRY_LIMIT  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [CNT_W-1:0]   req_count,
  input  logic               req_irq_mode,
  input  logic               dev_busy,
  input  logic               dev_drq,
  input  logic               dev_intrq,
  output logic               cmd_wr,
  output logic [CNT_W-1:0]   cmd_count,
  output logic               buf_rd,
  output logic               done,
  output logic               fail,
  output logic               dev_rst,
  output logic [LEASE_W-1:0] lease_val,
  output logic [2:0]         host_state
);
  logic [1:0]       rst_pipe_q;
  logic             rst_int_n;
  logic             lease_load, lease_zero;
  logic             retry_clear, retry_inc, retry_at_limit;
  logic             buf_load, buf_dec, buf_last, buf_empty;
  logic [CNT_W-1:0] buf_remaining;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  lease_timer #(.LEASE_W(LEASE_W), .LEASE_RELOAD(LEASE_RELOAD)) u_lease (
    .clk(clk), .rst_n(rst_int_n), .load(lease_load),
    .val(lease_val), .zero(lease_zero)
  );

  busy_retry_counter #(.RETRY_LIMIT(RETRY_LIMIT)) u_retry (
    .clk(clk), .rst_n(rst_int_n), .clear(retry_clear),
    .inc(retry_inc), .at_limit(retry_at_limit)
  );

  buffer_tracker #(.CNT_W(CNT_W)) u_bufs (
    .clk(clk), .rst_n(rst_int_n), .load(buf_load), .load_val(req_count),
    .dec(buf_dec), .remaining(buf_remaining), .last(buf_last), .empty(buf_empty)
  );

  pio_host_fsm #(.CNT_W(CNT_W), .MAX_COUNT(MAX_COUNT)) u_fsm (
    .clk(clk), .rst_n(rst_int_n),
    .req_valid(req_valid), .req_count(req_count), .req_irq_mode(req_irq_mode),
    .dev_busy(dev_busy), .dev_drq(dev_drq), .dev_intrq(dev_intrq),
    .lease_zero(lease_zero), .retry_at_limit(retry_at_limit),
    .buf_last(buf_last), .buf_empty(buf_empty), .buf_remaining(buf_remaining),
    .lease_load(lease_load), .retry_clear(retry_clear), .retry_inc(retry_inc),
    .buf_load(buf_load), .buf_dec(buf_dec),
    .cmd_wr(cmd_wr), .cmd_count(cmd_count), .buf_rd(buf_rd), .done(done),
    .fail(fail), .dev_rst(dev_rst), .state(host_state)
  );
endmodule

// File: rtl/lease_guard_pio_host_chk.sv
module lease_guard_pio_host_chk #(
  parameter int unsigned CNT_W        = 8,
  parameter int unsigned MAX_COUNT    = 127,
  parameter int unsigned LEASE_W      = 16,
  parameter int unsigned LEASE_RELOAD = 1000
) (
  input logic               clk,
  input logic               rst_n,
  input logic [CNT_W-1:0]   req_count,
  input logic               dev_busy,
  input logic               dev_drq,
  input logic               dev_intrq,
  input logic               cmd_wr,
  input logic               done,
  input logic               fail,
  input logic               dev_rst,
  input logic [LEASE_W-1:0] lease_val,
  input logic [2:0]         host_state
);
  localparam logic [LEASE_W-1:0] RELOAD_V = LEASE_W'(LEASE_RELOAD);
  localparam logic [CNT_W-1:0]   MAX_V    = CNT_W'(MAX_COUNT);

  p_reject_clean_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> (!cmd_wr && host_state == 3'd0 && $past(req_count) > MAX_V));

  p_cmd_after_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |-> ($past(host_state) == 3'd1 && !$past(dev_busy)));

  p_poll_needs_drq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (host_state == 3'd4 && $past(host_state) == 3'd3) |-> $past(dev_drq));

  p_int_needs_line_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (host_state == 3'd4 && $past(host_state) == 3'd2) |-> $past(dev_intrq));

  p_done_to_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> host_state == 3'd0);

  p_lease_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(lease_val) != '0 && lease_val != RELOAD_V) |-> lease_val == $past(lease_val) - 1'b1);

  p_lease_floor_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(lease_val) == '0) |-> (lease_val == '0 || lease_val == RELOAD_V));

  p_expiry_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_rst && ($past(host_state) == 3'd2 || $past(host_state) == 3'd3)) |->
      ($past(lease_val) == '0 && host_state == 3'd0));

  p_abort_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fail, dev_rst, done}));
endmodule

bind lease_guard_pio_host lease_guard_pio_host_chk #(
  .CNT_W(CNT_W), .MAX_COUNT(MAX_COUNT), .LEASE_W(LEASE_W), .LEASE_RELOAD(LEASE_RELOAD)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_count(req_count), .dev_busy(dev_busy),
  .dev_drq(dev_drq), .dev_intrq(dev_intrq), .cmd_wr(cmd_wr), .done(done),
  .fail(fail), .dev_rst(dev_rst), .lease_val(lease_val), .host_state(host_state)
);

// File: tb/tb_lease_guard_pio_host.sv
`timescale 1ns/100ps
module tb_lease_guard_pio_host;
  localparam int CW = 8;
  localparam int LW = 16;
  localparam int RELOAD = 20;
  localparam int RLIM = 4;

  logic clk, rst_n, req_valid, req_irq_mode, dev_busy, dev_drq, dev_intrq;
  logic [CW-1:0] req_count;
  logic cmd_wr, buf_rd, done, fail, dev_rst;
  logic [CW-1:0] cmd_count;
  logic [LW-1:0] lease_val;
  logic [2:0] host_state;

  int n_chk = 0, n_bad = 0;
  int c_cmd = 0, c_buf = 0, c_done = 0, c_fail = 0, c_rst = 0;
  int last_ccnt = 0;

  lease_guard_pio_host #(.CNT_W(CW), .MAX_COUNT(127), .LEASE_W(LW),
                         .LEASE_RELOAD(RELOAD), .RETRY_LIMIT(RLIM)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_count(req_count),
    .req_irq_mode(req_irq_mode), .dev_busy(dev_busy), .dev_drq(dev_drq),
    .dev_intrq(dev_intrq), .cmd_wr(cmd_wr), .cmd_count(cmd_count),
    .buf_rd(buf_rd), .done(done), .fail(fail), .dev_rst(dev_rst),
    .lease_val(lease_val), .host_state(host_state));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(negedge clk) begin
    if (cmd_wr) begin c_cmd++; last_ccnt = int'(cmd_count); end
    if (buf_rd) c_buf++;
    if (done) c_done++;
    if (fail) c_fail++;
    if (dev_rst) c_rst++;
  end

  typedef struct packed {
    logic [7:0] cnt;
    logic       irq;
    logic [3:0] busy;
    logic [3:0] dly;
    logic       exp_fail;
  } vec_t;

  localparam vec_t VECS [0:6] = '{
    '{8'd3,   1'b0, 4'd0, 4'd2, 1'b0},
    '{8'd1,   1'b1, 4'd2, 4'd0, 1'b0},
    '{8'd5,   1'b1, 4'd1, 4'd5, 1'b0},
    '{8'd0,   1'b0, 4'd0, 4'd0, 1'b0},
    '{8'd200, 1'b0, 4'd0, 4'd0, 1'b1},
    '{8'd127, 1'b0, 4'd3, 4'd0, 1'b0},
    '{8'd128, 1'b1, 4'd0, 4'd0, 1'b1}
  };

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic issue(input int cnt, input logic irq, input logic busy);
    req_valid = 1'b1; req_count = CW'(cnt); req_irq_mode = irq; dev_busy = busy;
    tick();
    req_valid = 1'b0;
  endtask

  task automatic pulse(input logic use_irq);
    if (use_irq) dev_intrq = 1'b1; else dev_drq = 1'b1;
    tick();
    dev_intrq = 1'b0; dev_drq = 1'b0;
  endtask

  task automatic run_vec(input vec_t v);
    int b_cmd, b_buf, b_done, b_fail, b_rst, guard;
    b_cmd = c_cmd; b_buf = c_buf; b_done = c_done; b_fail = c_fail; b_rst = c_rst;
    issue(int'(v.cnt), v.irq, v.busy != 0);
    if (v.exp_fail) begin
      tick();
      chk("R2 fail pulses", c_fail - b_fail, 1);
      chk("R2 no command", c_cmd - b_cmd, 0);
      chk("R2 stays idle", int'(host_state), 0);
      return;
    end
    for (int i = 1; i < int'(v.busy); i++) begin
      chk("R3 no command while busy", c_cmd - b_cmd, 0);
      tick();
    end
    dev_busy = 1'b0;
    guard = 0;
    while (c_done == b_done && guard < 2000) begin
      if (host_state == 3'd2 || host_state == 3'd3) begin
        chk("R4 wait state by mode", int'(host_state), v.irq ? 2 : 3);
        for (int d = 0; d < int'(v.dly); d++) tick();
        pulse(v.irq);
      end else begin
        tick();
      end
      guard++;
    end
    chk("R3 one command", c_cmd - b_cmd, 1);
    chk("R3 command count", last_ccnt, int'(v.cnt));
    chk(v.cnt == 0 ? "R7 no buffers for zero" : "R6 buffer reads", c_buf - b_buf, int'(v.cnt));
    chk("R6 one done", c_done - b_done, 1);
    chk("R6 back to idle", int'(host_state), 0);
    chk("R9 no device reset", c_rst - b_rst, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int b_buf, b_rst, b_done;
    rst_n = 1'b0; req_valid = 1'b0; req_count = '0; req_irq_mode = 1'b0;
    dev_busy = 1'b0; dev_drq = 1'b0; dev_intrq = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();
    // R1 reset state
    chk("R1 state idle", int'(host_state), 0);
    chk("R1 lease zero", int'(lease_val), 0);
    chk("R1 outputs low", int'({cmd_wr, buf_rd, done, fail, dev_rst}), 0);

    foreach (VECS[i]) run_vec(VECS[i]);

    // R8/R5/R9: interrupt mode, wrong indication then lease expiry
    b_buf = c_buf; b_rst = c_rst;
    issue(2, 1'b1, 1'b0);
    while (host_state != 3'd2) tick();
    chk("R8 lease reloaded", int'(lease_val), RELOAD);
    tick();
    chk("R8 lease minus one", int'(lease_val), RELOAD - 1);
    dev_drq = 1'b1;
    tick();
    dev_drq = 1'b0;
    chk("R5 drq ignored in interrupt mode", int'(host_state), 2);
    for (int k = 2; k < RELOAD; k++) tick();
    chk("R8 lease reaches zero", int'(lease_val), 0);
    chk("R9 still waiting at zero", int'(host_state), 2);
    tick();
    chk("R9 reset pulse", int'(dev_rst), 1);
    chk("R9 idle after expiry", int'(host_state), 0);
    repeat (3) tick();
    chk("R8 lease held at zero", int'(lease_val), 0);
    chk("R9 no buffers read", c_buf - b_buf, 0);
    chk("R9 one reset", c_rst - b_rst, 1);

    // R5: polled mode ignores the interrupt line
    b_buf = c_buf; b_done = c_done;
    issue(1, 1'b0, 1'b0);
    while (host_state != 3'd3) tick();
    pulse(1'b1);
    chk("R5 intrq ignored in poll mode", int'(host_state), 3);
    pulse(1'b0);
    chk("R5 drq moves to transfer", int'(host_state), 4);
    tick();
    chk("R5 one buffer", c_buf - b_buf, 1);
    chk("R5 done", c_done - b_done, 1);

    // R10: busy held past the retry limit
    b_rst = c_rst; b_done = c_done;
    begin
      int b_c;
      b_c = c_cmd;
      issue(4, 1'b0, 1'b1);
      for (int k = 1; k < RLIM; k++) tick();
      chk("R10 still checking", int'(host_state), 1);
      chk("R10 no reset yet", c_rst - b_rst, 0);
      tick();
      chk("R10 reset on limit", int'(dev_rst), 1);
      chk("R10 idle after limit", int'(host_state), 0);
      chk("R10 no command", c_cmd - b_c, 0);
      dev_busy = 1'b0;
    end

    // R11: request while active is ignored
    b_buf = c_buf; b_done = c_done;
    issue(2, 1'b0, 1'b0);
    while (host_state != 3'd3) tick();
    req_valid = 1'b1; req_count = 8'd50; req_irq_mode = 1'b1;
    tick();
    req_valid = 1'b0;
    chk("R11 mode kept", int'(host_state), 3);
    pulse(1'b0);
    while (host_state != 3'd3 && host_state != 3'd0) tick();
    pulse(1'b0);
    repeat (2) tick();
    chk("R11 count kept", c_buf - b_buf, 2);
    chk("R11 done once", c_done - b_done, 1);
    chk("R11 idle", int'(host_state), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule